// File: doc/BRIEF.md
# E1 Timeslot-0 Spare-Bit Inserter

This block supplies the E-bit and remote-alarm values that a transmit framer places into timeslot 0 of an outgoing E1 CRC4 multiframe. The receive side reports the CRC4 check of each submultiframe as it closes. The block buffers those results and reflects them back to the far end as E-bits in the next transmit multiframe. While the receiver has lost multiframe alignment, the block sends a configurable fixed E-bit value in their place. The remote-alarm indication follows the receive frame-alignment status without software action. A software force bit can also assert it.

The transmit framer gives the block a frame-start pulse and the number of the frame that is starting. The block registers the frame number and presents two things for that frame: whether the frame carries an E-bit, and which value to send. It also presents the A bit, which the framer inserts at bit 3 of timeslot 0 in the non-frame-alignment frames. Serialization of the timeslot and the CRC4 computation are done elsewhere.

Top module: `e1_ts0_spare`

## Requirements
- R1: After synchronous reset, tx_rai is 0, tx_ebit_slot is 0 and tx_ebit is 1. The receive buffer and the transmit E-bit buffer both hold 1 (no error).
- R2: On a cycle with rx_smf_done high, the receive buffer entry selected by rx_smf_idx is loaded with the inverted rx_smf_crc_err (0 = CRC error, 1 = no error). Entry 0 (first submultiframe) is sent in frame 13 and entry 1 (second submultiframe) is sent in frame 15.
- R3: The transmit E-bit buffer is loaded only on a cycle with tx_frame_start high and tx_frame_idx equal to 0. Receive results that arrive later do not appear until the next multiframe boundary.
- R4: On a cycle with tx_frame_start high, the block registers tx_frame_idx, and the outputs for that frame are valid from the next cycle. tx_ebit_slot is 1 only in frames 13 and 15. In all other frames tx_ebit is 1.
- R5: If rx_mf_async is high at the multiframe boundary, both transmit E-bits take the value of cfg_async_ebit. This holds whether or not automatic E-bits are enabled.
- R6: If cfg_auto_ebit is low and rx_mf_async is low at the multiframe boundary, both transmit E-bits are 1.
- R7: With cfg_auto_rai high and rx_lfa high at a frame start, tx_rai is 1 from the next cycle.
- R8: With rx_lfa low and cfg_rai_force low at a frame start, tx_rai returns to 0 from the next cycle.
- R9: tx_rai is the OR of cfg_rai_force and (cfg_auto_rai AND rx_lfa). With cfg_auto_rai low, rx_lfa has no effect.
- R10: tx_rai changes only in the cycle after a frame start. Changes of rx_lfa or of the configuration between frame starts do not show until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_frame_start | input | 1 | Pulse marking the start of a transmit frame |
| tx_frame_idx | input | 4 | Number (0..15) of the transmit frame that is starting |
| rx_smf_done | input | 1 | Pulse at the end of a received submultiframe |
| rx_smf_idx | input | 1 | Which submultiframe ended (0 first, 1 second) |
| rx_smf_crc_err | input | 1 | 1 if that submultiframe failed its CRC4 check |
| rx_lfa | input | 1 | Receive loss of basic frame alignment |
| rx_mf_async | input | 1 | Receive multiframe alignment not found |
| cfg_auto_ebit | input | 1 | Enable automatic E-bit reflection |
| cfg_async_ebit | input | 1 | E-bit value sent while multiframe is async |
| cfg_auto_rai | input | 1 | Enable automatic remote alarm on LFA |
| cfg_rai_force | input | 1 | Software remote-alarm force |
| tx_ebit_slot | output | 1 | Current frame carries an E-bit |
| tx_ebit | output | 1 | E-bit value for the current frame |
| tx_rai | output | 1 | A bit (remote alarm) for the current frame |

## Verification
The assertions assume that tx_frame_start is a single-cycle pulse, that tx_frame_idx is meaningful only while it is high, and that rx_smf_done never coincides with a multiframe-boundary frame start. With that coincidence ruled out, each buffer transfer can be attributed to one event. The stimulus meets these assumptions by building every pulse in its own task. Each task raises the pulse on one falling edge and drops it on the next. Receive reports and frame starts are never issued at the same time. Configuration and status inputs change only between pulses.

// File: rtl/e1sb_pkg.sv
package e1sb_pkg;

    // Where the transmit E-bits come from at a multiframe boundary
    typedef enum logic [1:0] {
        EB_SRC_RX    = 2'd0,
        EB_SRC_ASYNC = 2'd1,
        EB_SRC_IDLE  = 2'd2
    } ebit_src_e;

    // Transmit-side spare-bit state for the current frame
    typedef struct packed {
        logic slot;
        logic ebit;
        logic rai;
    } spare_bits_t;

    // E-bit polarity: 0 reports a CRC error, 1 reports a clean submultiframe
    function automatic logic ebit_from_err(input logic crc_err);
        return ~crc_err;
    endfunction

    // Frame number that carries the E-bit for submultiframe n
    function automatic int ebit_frame(input int base, input int step, input int n);
        return base + step * n;
    endfunction

endpackage

// File: rtl/e1sb_rx_latch.sv
module e1sb_rx_latch #(
    parameter int NUM_SMF = 2,
    localparam int IW = (NUM_SMF > 1) ? $clog2(NUM_SMF) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  logic [IW-1:0]      idx,
    input  logic               crc_err,
    output logic [NUM_SMF-1:0] rx_buf
);
    import e1sb_pkg::*;

    for (genvar g = 0; g < NUM_SMF; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                rx_buf[g] <= 1'b1;
            else if (done && idx == IW'(g))
                rx_buf[g] <= ebit_from_err(crc_err);
        end
    end

endmodule

// File: rtl/e1sb_tx_hold.sv
module e1sb_tx_hold #(
    parameter int NUM_SMF = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mf_start,
    input  logic [NUM_SMF-1:0] rx_buf,
    input  logic               mf_async,
    input  logic               async_val,
    input  logic               auto_en,
    output logic [NUM_SMF-1:0] ebuf
);
    import e1sb_pkg::*;

    ebit_src_e          src;
    logic [NUM_SMF-1:0] next_ebuf;

    always_comb begin
        if (mf_async)
            src = EB_SRC_ASYNC;
        else if (auto_en)
            src = EB_SRC_RX;
        else
            src = EB_SRC_IDLE;

        case (src)
            EB_SRC_RX:    next_ebuf = rx_buf;
            EB_SRC_ASYNC: next_ebuf = {NUM_SMF{async_val}};
            default:      next_ebuf = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            ebuf <= '1;
        else if (mf_start)
            ebuf <= next_ebuf;
    end

endmodule

// File: rtl/e1sb_rai.sv
module e1sb_rai (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic lfa,
    input  logic auto_en,
    input  logic force_on,
    output logic rai
);

    always_ff @(posedge clk) begin
        if (rst)
            rai <= 1'b0;
        else if (frame_start)
            rai <= (auto_en & lfa) | force_on;
    end

endmodule

// File: rtl/e1_ts0_spare.sv
module e1_ts0_spare #(
    parameter int MF_LEN    = 16,
    parameter int NUM_SMF   = 2,
    parameter int EBIT_BASE = 13,
    parameter int EBIT_STEP = 2,
    localparam int FW = $clog2(MF_LEN),
    localparam int IW = (NUM_SMF > 1) ? $clog2(NUM_SMF) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_frame_start,
    input  logic [FW-1:0] tx_frame_idx,
    input  logic          rx_smf_done,
    input  logic [IW-1:0] rx_smf_idx,
    input  logic          rx_smf_crc_err,
    input  logic          rx_lfa,
    input  logic          rx_mf_async,
    input  logic          cfg_auto_ebit,
    input  logic          cfg_async_ebit,
    input  logic          cfg_auto_rai,
    input  logic          cfg_rai_force,
    output logic          tx_ebit_slot,
    output logic          tx_ebit,
    output logic          tx_rai
);
    import e1sb_pkg::*;

    logic [FW-1:0]      frame_q;
    logic [NUM_SMF-1:0] rx_buf;
    logic [NUM_SMF-1:0] ebuf_q;
    logic [NUM_SMF-1:0] hit;
    logic               mf_start;
    logic               rai_q;
    spare_bits_t        bits;

    assign mf_start = tx_frame_start && (tx_frame_idx == '0);

    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= '0;
        else if (tx_frame_start)
            frame_q <= tx_frame_idx;
    end

    e1sb_rx_latch #(.NUM_SMF(NUM_SMF)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .done    (rx_smf_done),
        .idx     (rx_smf_idx),
        .crc_err (rx_smf_crc_err),
        .rx_buf  (rx_buf)
    );

    e1sb_tx_hold #(.NUM_SMF(NUM_SMF)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .mf_start  (mf_start),
        .rx_buf    (rx_buf),
        .mf_async  (rx_mf_async),
        .async_val (cfg_async_ebit),
        .auto_en   (cfg_auto_ebit),
        .ebuf      (ebuf_q)
    );

    e1sb_rai u_rai (
        .clk         (clk),
        .rst         (rst),
        .frame_start (tx_frame_start),
        .lfa         (rx_lfa),
        .auto_en     (cfg_auto_rai),
        .force_on    (cfg_rai_force),
        .rai         (rai_q)
    );

    for (genvar g = 0; g < NUM_SMF; g++) begin : g_pos
        assign hit[g] = (frame_q == FW'(ebit_frame(EBIT_BASE, EBIT_STEP, g)));
    end

    always_comb begin
        bits.slot = |hit;
        bits.ebit = &(~hit | ebuf_q);
        bits.rai  = rai_q;
    end

    assign tx_ebit_slot = bits.slot;
    assign tx_ebit      = bits.ebit;
    assign tx_rai       = bits.rai;

endmodule

// File: rtl/e1_ts0_spare_chk.sv
module e1_ts0_spare_chk #(
    parameter int NUM_SMF = 2,
    parameter int FW      = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               tx_frame_start,
    input logic [FW-1:0]      tx_frame_idx,
    input logic               rx_lfa,
    input logic               rx_mf_async,
    input logic               cfg_auto_rai,
    input logic               cfg_async_ebit,
    input logic               cfg_rai_force,
    input logic [NUM_SMF-1:0] ebuf_q,
    input logic               tx_rai
);

    // R3: transmit E-bits hold between multiframe boundaries
    a_r3_ebits_hold: assert property (@(posedge clk) disable iff (rst)
        !(tx_frame_start && tx_frame_idx == '0) |=> $stable(ebuf_q));

    // R5: async state forces both E-bits to the configured value
    a_r5_async_force: assert property (@(posedge clk) disable iff (rst)
        (tx_frame_start && tx_frame_idx == '0 && rx_mf_async)
        |=> ebuf_q == {NUM_SMF{$past(cfg_async_ebit)}});

    // R7: auto remote alarm on loss of frame alignment
    a_r7_rai_on_lfa: assert property (@(posedge clk) disable iff (rst)
        (tx_frame_start && cfg_auto_rai && rx_lfa) |=> tx_rai);

    // R8: alarm clears once alignment returns and no force is present
    a_r8_rai_clear: assert property (@(posedge clk) disable iff (rst)
        (tx_frame_start && !rx_lfa && !cfg_rai_force) |=> !tx_rai);

    // R9: software force asserts the alarm
    a_r9_rai_force: assert property (@(posedge clk) disable iff (rst)
        (tx_frame_start && cfg_rai_force) |=> tx_rai);

    // R10: alarm changes only after a frame start
    a_r10_rai_framed: assert property (@(posedge clk) disable iff (rst)
        !tx_frame_start |=> $stable(tx_rai));

endmodule

bind e1_ts0_spare e1_ts0_spare_chk #(.NUM_SMF(NUM_SMF), .FW(FW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_frame_start (tx_frame_start),
    .tx_frame_idx   (tx_frame_idx),
    .rx_lfa         (rx_lfa),
    .rx_mf_async    (rx_mf_async),
    .cfg_auto_rai   (cfg_auto_rai),
    .cfg_async_ebit (cfg_async_ebit),
    .cfg_rai_force  (cfg_rai_force),
    .ebuf_q         (ebuf_q),
    .tx_rai         (tx_rai)
);

// File: tb/test_e1_ts0_spare.sv
`timescale 1ns/1ps
module test_e1_ts0_spare;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_frame_start = 1'b0;
    logic [3:0] tx_frame_idx = '0;
    logic       rx_smf_done = 1'b0;
    logic       rx_smf_idx = 1'b0;
    logic       rx_smf_crc_err = 1'b0;
    logic       rx_lfa = 1'b0;
    logic       rx_mf_async = 1'b0;
    logic       cfg_auto_ebit = 1'b1;
    logic       cfg_async_ebit = 1'b0;
    logic       cfg_auto_rai = 1'b0;
    logic       cfg_rai_force = 1'b0;
    logic       tx_ebit_slot, tx_ebit, tx_rai;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    e1_ts0_spare i_e1_ts0_spare (
        .clk (clk), .rst (rst),
        .tx_frame_start (tx_frame_start), .tx_frame_idx (tx_frame_idx),
        .rx_smf_done (rx_smf_done), .rx_smf_idx (rx_smf_idx),
        .rx_smf_crc_err (rx_smf_crc_err),
        .rx_lfa (rx_lfa), .rx_mf_async (rx_mf_async),
        .cfg_auto_ebit (cfg_auto_ebit), .cfg_async_ebit (cfg_async_ebit),
        .cfg_auto_rai (cfg_auto_rai), .cfg_rai_force (cfg_rai_force),
        .tx_ebit_slot (tx_ebit_slot), .tx_ebit (tx_ebit), .tx_rai (tx_rai)
    );

    // Vector fields: [6] err first smf, [5] err second smf, [4] async,
    // [3] async E-bit value, [2] auto E-bit, [1] expected frame 13, [0] expected frame 15
    localparam logic [6:0] VEC [8] = '{
        7'b0000111, 7'b1000101, 7'b0100110, 7'b1100100,
        7'b1111111, 7'b0010100, 7'b1100011, 7'b0010000
    };

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic frame(input int n);
        @(negedge clk);
        tx_frame_start = 1'b1;
        tx_frame_idx   = 4'(n);
        @(negedge clk);
        tx_frame_start = 1'b0;
    endtask

    task automatic report(input logic which, input logic err);
        @(negedge clk);
        rx_smf_done    = 1'b1;
        rx_smf_idx     = which;
        rx_smf_crc_err = err;
        @(negedge clk);
        rx_smf_done    = 1'b0;
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx_rai, 1'b0, "R1", "rai after reset");
        check(tx_ebit_slot, 1'b0, "R1", "slot after reset");
        check(tx_ebit, 1'b1, "R1", "ebit after reset");
        frame(13);
        check(tx_ebit, 1'b1, "R1", "reset E-bit frame 13");

        // Vector walk: R2, R5, R6, R4
        for (int v = 0; v < 8; v++) begin
            string tag;
            logic [6:0] e;
            e = VEC[v];
            tag = e[4] ? "R5" : (!e[2] ? "R6" : "R2");
            report(1'b0, e[6]);
            report(1'b1, e[5]);
            rx_mf_async    = e[4];
            cfg_async_ebit = e[3];
            cfg_auto_ebit  = e[2];
            frame(0);
            check(tx_ebit_slot, 1'b0, "R4", "slot frame 0");
            check(tx_ebit, 1'b1, "R4", "ebit frame 0");
            frame(13);
            check(tx_ebit_slot, 1'b1, tag, "slot frame 13");
            check(tx_ebit, e[1], tag, "ebit frame 13");
            frame(14);
            check(tx_ebit_slot, 1'b0, "R4", "slot frame 14");
            frame(15);
            check(tx_ebit_slot, 1'b1, tag, "slot frame 15");
            check(tx_ebit, e[0], tag, "ebit frame 15");
        end
        rx_mf_async   = 1'b0;
        cfg_auto_ebit = 1'b1;

        // R3: new results after the boundary wait for the next multiframe
        report(1'b0, 1'b0);
        report(1'b1, 1'b0);
        frame(0);
        report(1'b0, 1'b1);
        report(1'b1, 1'b1);
        frame(13);
        check(tx_ebit, 1'b1, "R3", "frame 13 keeps old value");
        frame(15);
        check(tx_ebit, 1'b1, "R3", "frame 15 keeps old value");
        frame(0);
        frame(13);
        check(tx_ebit, 1'b0, "R3", "frame 13 new value");
        frame(15);
        check(tx_ebit, 1'b0, "R3", "frame 15 new value");

        // R10 / R7: LFA between frame starts does not act yet
        cfg_auto_rai = 1'b1;
        @(negedge clk);
        rx_lfa = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_rai, 1'b0, "R10", "rai before frame start");
        frame(1);
        check(tx_rai, 1'b1, "R7", "rai on LFA");
        // R8: alignment regained
        rx_lfa = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_rai, 1'b1, "R10", "rai held mid frame");
        frame(2);
        check(tx_rai, 1'b0, "R8", "rai cleared");
        // R9: auto disabled ignores LFA, force ORs in
        cfg_auto_rai = 1'b0;
        rx_lfa = 1'b1;
        frame(3);
        check(tx_rai, 1'b0, "R9", "LFA ignored without auto");
        cfg_rai_force = 1'b1;
        frame(4);
        check(tx_rai, 1'b1, "R9", "force sets rai");
        cfg_rai_force = 1'b0;
        frame(5);
        check(tx_rai, 1'b0, "R9", "force removed");

        // R1: reset in mid run
        cfg_rai_force = 1'b1;
        frame(13);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_rai_force = 1'b0;
        check(tx_rai, 1'b0, "R1", "rai after second reset");
        check(tx_ebit_slot, 1'b0, "R1", "slot after second reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule